// File: doc/BRIEF.md
# Typed Interrupt Pending Register

This block holds the pending state of up to 32 processor interrupts. Every bit is given one kind at elaboration time (level, edge, software, timer or non-maskable) by a set of disjoint parameter masks. The kind of a bit decides which sources may set it and which may clear it. The sources are the per-line hardware inputs, a core set port, a core clear port, and a strobe per timer-compare register.

All sources are merged into one register update per cycle. The merge removes every bit that any source clears and then adds every bit that any source sets. Simultaneous events from hardware and from the core therefore never overwrite one another. Where a set and a clear hit the same bit in the same cycle, the set wins.

The block drives the pending vector and a single request output. The request output is formed with a separate enable mask, and the non-maskable bit does not need that mask.

Top module: `irq_pending_reg`

## Requirements
- R1: While `rst_ni` is low, `pending_o` is all zero and `irq_o` is low. The edge-detect history is also cleared, so a line that is high when reset is released counts as a new rising edge.
- R2: A level-kind bit equals its hardware line as sampled at the previous clock edge. It is set while the line is high and cleared when the line is low.
- R3: An edge-kind, timer-kind or non-maskable bit is set one cycle after its line goes from 0 to 1. It stays set after the line falls and while the line stays high.
- R4: A core set write (`set_we_i`) ORs `set_data_i` into the register after masking it with the software-kind mask. It never clears a bit and never sets a bit of another kind.
- R5: A core clear write (`clr_we_i`) clears only the bits that are 1 in `clr_data_i` and are of software or edge kind. Level, timer and non-maskable bits are not affected by it.
- R6: A pulse on `timer_we_i[t]` clears the pending bit tied to timer t. With the default parameters, timers 0, 1 and 2 are tied to bits 24, 25 and 26.
- R7: All sources that act in one cycle take effect together: next = (current & ~all_clears) | all_sets. A set beats a clear on the same bit, and bits handled by different sources never interfere.
- R8: `irq_o` is high exactly when some pending bit is also enabled in `enable_i`, or when the non-maskable bit is pending, whatever `enable_i` holds.
- R9: A software-kind bit is also set while its hardware line is high. It stays set after the line falls, until a clear write removes it.
- Default kinds: level bits 0 to 7 and 28 to 31, edge bits 8 to 15, software bits 16 to 23, timer bits 24 to 26, non-maskable bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | NUM_IRQ | Hardware interrupt lines, one per bit |
| set_we_i | input | 1 | Core set write strobe |
| set_data_i | input | NUM_IRQ | Core set write data |
| clr_we_i | input | 1 | Core clear write strobe |
| clr_data_i | input | NUM_IRQ | Core clear write data |
| timer_we_i | input | NUM_TIMER | Timer-compare write strobes, one per timer |
| enable_i | input | NUM_IRQ | Interrupt enable mask |
| pending_o | output | NUM_IRQ | Pending vector |
| irq_o | output | 1 | High when an enabled bit or the non-maskable bit is pending |

## Verification
Some rules are checked on every cycle:
- Level bits follow their lines with one cycle of delay.
- Edge bits drop only under a clear write that names them.
- A set write alone never removes a non-level bit.
- The non-maskable bit is never lost once it is set.
- A timer strobe with its line low leaves its bit clear.
- The request output agrees with the enabled and non-maskable pending bits.

Other behaviour can only be shown by the bench's scenarios. These are the exact merged value when several sources collide in one cycle, and the precedence of a set over a clear. The bench also shows that a clear write does not touch level, timer or non-maskable bits, and that reset release is treated as a rising edge.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int unsigned MAX_IRQ = 64;

  typedef enum logic [2:0] {
    KIND_LEVEL,
    KIND_EDGE,
    KIND_SOFT,
    KIND_TIMER,
    KIND_NMI,
    KIND_NONE
  } irq_kind_e;

  // Kind of bit idx from the disjoint masks; level is checked first.
  function automatic irq_kind_e kind_of(
    input int unsigned          idx,
    input logic [MAX_IRQ-1:0]   level_m,
    input logic [MAX_IRQ-1:0]   edge_m,
    input logic [MAX_IRQ-1:0]   soft_m,
    input logic [MAX_IRQ-1:0]   timer_m,
    input logic [MAX_IRQ-1:0]   nmi_m
  );
    if (level_m[idx])      return KIND_LEVEL;
    else if (edge_m[idx])  return KIND_EDGE;
    else if (soft_m[idx])  return KIND_SOFT;
    else if (timer_m[idx]) return KIND_TIMER;
    else if (nmi_m[idx])   return KIND_NMI;
    else                   return KIND_NONE;
  endfunction

endpackage

// File: rtl/irq_hw_detect.sv
module irq_hw_detect
  import irq_pend_pkg::*;
#(
  parameter int unsigned          NUM_IRQ    = 32,
  parameter logic [NUM_IRQ-1:0]   LEVEL_MASK = '0,
  parameter logic [NUM_IRQ-1:0]   EDGE_MASK  = '0,
  parameter logic [NUM_IRQ-1:0]   SOFT_MASK  = '0,
  parameter logic [NUM_IRQ-1:0]   TIMER_MASK = '0,
  parameter logic [NUM_IRQ-1:0]   NMI_MASK   = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] line_i,
  output logic [NUM_IRQ-1:0] set_o,
  output logic [NUM_IRQ-1:0] clr_o
);

  localparam logic [MAX_IRQ-1:0] LVL_W = MAX_IRQ'(LEVEL_MASK);
  localparam logic [MAX_IRQ-1:0] EDG_W = MAX_IRQ'(EDGE_MASK);
  localparam logic [MAX_IRQ-1:0] SFT_W = MAX_IRQ'(SOFT_MASK);
  localparam logic [MAX_IRQ-1:0] TMR_W = MAX_IRQ'(TIMER_MASK);
  localparam logic [MAX_IRQ-1:0] NMI_W = MAX_IRQ'(NMI_MASK);

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    localparam irq_kind_e KIND = kind_of(b, LVL_W, EDG_W, SFT_W, TMR_W, NMI_W);

    if (KIND == KIND_LEVEL) begin : g_level
      assign set_o[b] = line_i[b];
      assign clr_o[b] = ~line_i[b];
    end else if (KIND == KIND_EDGE || KIND == KIND_TIMER || KIND == KIND_NMI) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= line_i[b];
      end
      assign set_o[b] = line_i[b] & ~prev_q;
      assign clr_o[b] = 1'b0;
    end else if (KIND == KIND_SOFT) begin : g_soft
      assign set_o[b] = line_i[b];
      assign clr_o[b] = 1'b0;
    end else begin : g_none
      assign set_o[b] = 1'b0;
      assign clr_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_sw_port.sv
module irq_sw_port #(
  parameter int unsigned          NUM_IRQ   = 32,
  parameter logic [NUM_IRQ-1:0]   EDGE_MASK = '0,
  parameter logic [NUM_IRQ-1:0]   SOFT_MASK = '0,
  parameter logic [NUM_IRQ-1:0]   NMI_MASK  = '0
) (
  input  logic               set_we_i,
  input  logic [NUM_IRQ-1:0] set_data_i,
  input  logic               clr_we_i,
  input  logic [NUM_IRQ-1:0] clr_data_i,
  output logic [NUM_IRQ-1:0] set_o,
  output logic [NUM_IRQ-1:0] clr_o
);

  localparam logic [NUM_IRQ-1:0] SET_OK = SOFT_MASK;
  // NMI excluded explicitly even if a mask overlap slips in
  localparam logic [NUM_IRQ-1:0] CLR_OK = (SOFT_MASK | EDGE_MASK) & ~NMI_MASK;

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (set_we_i) set_o = set_data_i & SET_OK;
    if (clr_we_i) clr_o = clr_data_i & CLR_OK;
  end

endmodule

// File: rtl/irq_timer_clr.sv
module irq_timer_clr #(
  parameter int unsigned NUM_IRQ              = 32,
  parameter int unsigned NUM_TIMER            = 3,
  parameter int unsigned TIMER_BIT[NUM_TIMER] = '{24, 25, 26}
) (
  input  logic [NUM_TIMER-1:0] timer_we_i,
  output logic [NUM_IRQ-1:0]   clr_o
);

  logic [NUM_TIMER-1:0][NUM_IRQ-1:0] per_timer;

  for (genvar t = 0; t < NUM_TIMER; t++) begin : g_tmr
    localparam logic [NUM_IRQ-1:0] ONE_HOT = NUM_IRQ'(1) << TIMER_BIT[t];
    assign per_timer[t] = timer_we_i[t] ? ONE_HOT : '0;
  end

  always_comb begin
    clr_o = '0;
    for (int t = 0; t < NUM_TIMER; t++) clr_o |= per_timer[t];
  end

endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int unsigned          NUM_IRQ              = 32,
  parameter int unsigned          NUM_TIMER            = 3,
  parameter logic [NUM_IRQ-1:0]   LEVEL_MASK           = 32'hF000_00FF,
  parameter logic [NUM_IRQ-1:0]   EDGE_MASK            = 32'h0000_FF00,
  parameter logic [NUM_IRQ-1:0]   SOFT_MASK            = 32'h00FF_0000,
  parameter logic [NUM_IRQ-1:0]   TIMER_MASK           = 32'h0700_0000,
  parameter logic [NUM_IRQ-1:0]   NMI_MASK             = 32'h0800_0000,
  parameter int unsigned          TIMER_BIT[NUM_TIMER] = '{24, 25, 26}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   irq_line_i,
  input  logic                 set_we_i,
  input  logic [NUM_IRQ-1:0]   set_data_i,
  input  logic                 clr_we_i,
  input  logic [NUM_IRQ-1:0]   clr_data_i,
  input  logic [NUM_TIMER-1:0] timer_we_i,
  input  logic [NUM_IRQ-1:0]   enable_i,
  output logic [NUM_IRQ-1:0]   pending_o,
  output logic                 irq_o
);

  logic [NUM_IRQ-1:0] hw_set, hw_clr;
  logic [NUM_IRQ-1:0] sw_set, sw_clr;
  logic [NUM_IRQ-1:0] tmr_clr;
  logic [NUM_IRQ-1:0] set_all, clr_all;
  logic [NUM_IRQ-1:0] pend_q, pend_d;

  irq_hw_detect #(
    .NUM_IRQ   (NUM_IRQ),
    .LEVEL_MASK(LEVEL_MASK),
    .EDGE_MASK (EDGE_MASK),
    .SOFT_MASK (SOFT_MASK),
    .TIMER_MASK(TIMER_MASK),
    .NMI_MASK  (NMI_MASK)
  ) i_hw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(irq_line_i),
    .set_o (hw_set),
    .clr_o (hw_clr)
  );

  irq_sw_port #(
    .NUM_IRQ  (NUM_IRQ),
    .EDGE_MASK(EDGE_MASK),
    .SOFT_MASK(SOFT_MASK),
    .NMI_MASK (NMI_MASK)
  ) i_sw (
    .set_we_i  (set_we_i),
    .set_data_i(set_data_i),
    .clr_we_i  (clr_we_i),
    .clr_data_i(clr_data_i),
    .set_o     (sw_set),
    .clr_o     (sw_clr)
  );

  irq_timer_clr #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_TIMER(NUM_TIMER),
    .TIMER_BIT(TIMER_BIT)
  ) i_tmr (
    .timer_we_i(timer_we_i),
    .clr_o     (tmr_clr)
  );

  // Single merge point: clears first, sets override
  assign clr_all = hw_clr | sw_clr | tmr_clr;
  assign set_all = hw_set | sw_set;
  assign pend_d  = (pend_q & ~clr_all) | set_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pending_o = pend_q;
  assign irq_o     = |(pend_q & (enable_i | NMI_MASK));

endmodule

// File: rtl/irq_pending_chk.sv
module irq_pending_chk #(
  parameter int unsigned          NUM_IRQ              = 32,
  parameter int unsigned          NUM_TIMER            = 3,
  parameter logic [NUM_IRQ-1:0]   LEVEL_MASK           = '0,
  parameter logic [NUM_IRQ-1:0]   EDGE_MASK            = '0,
  parameter logic [NUM_IRQ-1:0]   NMI_MASK             = '0,
  parameter int unsigned          TIMER_BIT[NUM_TIMER] = '{24, 25, 26}
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_IRQ-1:0]   irq_line_i,
  input logic                 set_we_i,
  input logic                 clr_we_i,
  input logic [NUM_IRQ-1:0]   clr_data_i,
  input logic [NUM_TIMER-1:0] timer_we_i,
  input logic [NUM_IRQ-1:0]   enable_i,
  input logic [NUM_IRQ-1:0]   pending_o,
  input logic                 irq_o
);

  logic [NUM_IRQ-1:0] clr_seen;
  assign clr_seen = clr_we_i ? clr_data_i : '0;

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (pending_o == '0) || rst_ni);

  a_r2_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pending_o & LEVEL_MASK) == ($past(irq_line_i) & LEVEL_MASK));

  a_r3_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pending_o) & EDGE_MASK) & ~pending_o) & ~$past(clr_seen)) == '0);

  a_r4_set_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i && timer_we_i == '0)
      |=> ((pending_o & $past(pending_o) & ~LEVEL_MASK) == ($past(pending_o) & ~LEVEL_MASK)));

  a_r5_nmi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending_o & $past(pending_o) & NMI_MASK) == ($past(pending_o) & NMI_MASK)));

  for (genvar t = 0; t < NUM_TIMER; t++) begin : g_tchk
    a_r6_timer_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timer_we_i[t] && !irq_line_i[TIMER_BIT[t]]) |=> !pending_o[TIMER_BIT[t]]);
  end

  a_r8_nmi_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pending_o & NMI_MASK) != '0) |-> irq_o);

  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pending_o & enable_i) == '0 && (pending_o & NMI_MASK) == '0) |-> !irq_o);

endmodule

bind irq_pending_reg irq_pending_chk #(
  .NUM_IRQ   (NUM_IRQ),
  .NUM_TIMER (NUM_TIMER),
  .LEVEL_MASK(LEVEL_MASK),
  .EDGE_MASK (EDGE_MASK),
  .NMI_MASK  (NMI_MASK),
  .TIMER_BIT (TIMER_BIT)
) i_irq_pending_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_line_i(irq_line_i),
  .set_we_i  (set_we_i),
  .clr_we_i  (clr_we_i),
  .clr_data_i(clr_data_i),
  .timer_we_i(timer_we_i),
  .enable_i  (enable_i),
  .pending_o (pending_o),
  .irq_o     (irq_o)
);

// File: tb/test_irq_pending_reg.sv
module test_irq_pending_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_line_i = '0;
  logic        set_we_i = 1'b0;
  logic [31:0] set_data_i = '0;
  logic        clr_we_i = 1'b0;
  logic [31:0] clr_data_i = '0;
  logic [2:0]  timer_we_i = '0;
  logic [31:0] enable_i = '0;
  logic [31:0] pending_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_pending_reg i_irq_pending_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_line_i(irq_line_i),
    .set_we_i(set_we_i), .set_data_i(set_data_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .timer_we_i(timer_we_i), .enable_i(enable_i),
    .pending_o(pending_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe_idle();
    set_we_i = 1'b0; clr_we_i = 1'b0; timer_we_i = '0;
    set_data_i = '0; clr_data_i = '0;
  endtask

  task automatic do_reset();
    strobe_idle();
    irq_line_i = '0; enable_i = '0;
    rst_ni = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_reset();  // R1
    irq_line_i = 32'hFFFF_FFFF;
    rst_ni = 1'b0;
    tick();
    chk("R1 pending in reset", pending_o, 32'h0);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    irq_line_i = '0;
    tick();
    rst_ni = 1'b1;
    irq_line_i = 32'h0000_0100;
    tick();
    chk("R1 rising at reset release", pending_o, 32'h0000_0100);
  endtask

  task automatic t_level();  // R2
    do_reset();
    irq_line_i[3] = 1'b1;
    tick();
    chk("R2 level set", pending_o, 32'h0000_0008);
    irq_line_i[3] = 1'b0;
    tick();
    chk("R2 level cleared", pending_o, 32'h0);
  endtask

  task automatic t_edge();  // R3
    do_reset();
    irq_line_i[9] = 1'b1;
    tick();
    chk("R3 edge set", pending_o, 32'h0000_0200);
    tick();
    chk("R3 edge held while high", pending_o, 32'h0000_0200);
    irq_line_i[9] = 1'b0;
    tick();
    chk("R3 edge sticky after drop", pending_o, 32'h0000_0200);
  endtask

  task automatic t_sw_set();  // R4
    do_reset();
    irq_line_i[0] = 1'b1; irq_line_i[8] = 1'b1;
    tick();
    set_we_i = 1'b1; set_data_i = 32'hFFFF_FFFF;
    tick();
    chk("R4 set masked to software kind", pending_o, 32'h00FF_0101);
    set_data_i = 32'h0;
    tick();
    strobe_idle();
    chk("R4 set of zero clears nothing", pending_o, 32'h00FF_0101);
  endtask

  task automatic t_sw_clear();  // R5
    do_reset();
    set_we_i = 1'b1; set_data_i = 32'h00FF_0000;
    tick();
    strobe_idle();
    irq_line_i = 32'h0900_0101;
    tick();
    chk("R5 setup", pending_o, 32'h09FF_0101);
    clr_we_i = 1'b1; clr_data_i = 32'hFFFF_FFFF;
    tick();
    strobe_idle();
    chk("R5 clear spares level timer nmi", pending_o, 32'h0900_0001);
  endtask

  task automatic t_timer();  // R6
    do_reset();
    irq_line_i[24] = 1'b1; irq_line_i[25] = 1'b1;
    tick();
    irq_line_i = '0;
    tick();
    chk("R6 timer bits sticky", pending_o, 32'h0300_0000);
    timer_we_i = 3'b001;
    tick();
    strobe_idle();
    chk("R6 timer0 clears bit24", pending_o, 32'h0200_0000);
    timer_we_i = 3'b100;
    tick();
    strobe_idle();
    chk("R6 timer2 leaves others", pending_o, 32'h0200_0000);
  endtask

  task automatic t_merge();  // R7
    do_reset();
    set_we_i = 1'b1; set_data_i = 32'h0003_0000;
    irq_line_i[26] = 1'b1;
    tick();
    strobe_idle();
    chk("R7 setup", pending_o, 32'h0403_0000);
    set_we_i = 1'b1; set_data_i = 32'h0005_0000;
    clr_we_i = 1'b1; clr_data_i = 32'h0003_0000;
    timer_we_i = 3'b100;
    irq_line_i[10] = 1'b1; irq_line_i[0] = 1'b1;
    tick();
    strobe_idle();
    chk("R7 same-cycle merge", pending_o, 32'h0005_0401);
    timer_we_i = 3'b001;
    irq_line_i[24] = 1'b1;
    tick();
    strobe_idle();
    chk("R7 rising beats timer clear", pending_o, 32'h0105_0401);
  endtask

  task automatic t_irq();  // R8
    do_reset();
    set_we_i = 1'b1; set_data_i = 32'h0001_0000;
    tick();
    strobe_idle();
    chk("R8 disabled quiet", {31'b0, irq_o}, 32'h0);
    enable_i = 32'h0002_0000;
    #1;
    chk("R8 other enable quiet", {31'b0, irq_o}, 32'h0);
    enable_i = 32'h0001_0000;
    #1;
    chk("R8 enabled fires", {31'b0, irq_o}, 32'h1);
    enable_i = '0;
    clr_we_i = 1'b1; clr_data_i = 32'h0001_0000;
    irq_line_i[27] = 1'b1;
    tick();
    strobe_idle();
    chk("R8 nmi bypasses enable", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_sw_line();  // R9
    do_reset();
    irq_line_i[20] = 1'b1;
    tick();
    chk("R9 software line sets", pending_o, 32'h0010_0000);
    irq_line_i[20] = 1'b0;
    tick();
    chk("R9 software bit held", pending_o, 32'h0010_0000);
    clr_we_i = 1'b1; clr_data_i = 32'h0010_0000;
    tick();
    strobe_idle();
    chk("R9 cleared by clear write", pending_o, 32'h0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_sw_set();
    t_sw_clear();
    t_timer();
    t_merge();
    t_irq();
    t_sw_line();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule